// File: doc/BRIEF.md
# Nested Priority Interrupt Controller with Vector Output

This block sits between a set of interrupting devices and a processor. Each device line sets a pending flag. A software-loaded mask register allows or blocks each device. A fixed-priority arbiter picks the most urgent device that is pending, allowed and not already in service. It raises a single request line to the processor while a global switch is on. When the processor acknowledges, the controller presents an 8-bit vector address in that same cycle and marks the chosen device as in service.

The block keeps one in-service bit per device, so service routines can nest. A device more urgent than every device in service interrupts the current routine. Devices of equal or lower urgency wait, whatever order they arrived in. An end-of-service strobe retires the most urgent active level and clears its pending flag. The interrupted routine then continues, and any waiting requests are considered again.

Device numbers run from 1 to NUM_DEV, and device 1 is the most urgent. The vector is hexadecimal F in the upper nibble, with the device number in the lower nibble.

Top module: `vnpic_top`

## Requirements
- R1: After reset every pending flag, mask bit and in-service bit is zero, `int_req` is 0 and `vector` is 0x00.
- R2: A high `irq_in[i]` sets the pending flag of device i+1. The flag persists while its mask bit is 0, and that device then cannot raise `int_req`. A cycle with `en_wr` high loads `en_data` into the mask register, where 1 allows a device.
- R3: While `gie` is 0, `int_req` is 0, and pending flags are kept.
- R4: Among devices that are pending, allowed and not in service, the lowest device number is chosen.
- R5: In a cycle where `int_ack` and `int_req` are both high, `vector` equals 0xF0 plus the chosen device number (device 6 gives 0xF6). In every other cycle `vector` is 0x00.
- R6: An acknowledged request marks its device as in service on that clock edge.
- R7: `int_req` is raised for a candidate only when its number is lower than the number of every device in service.
- R8: A pending device whose number is equal to or higher than that of an in-service device does not raise `int_req`, even if it arrived first.
- R9: A cycle with `eoi` high clears the in-service bit and the pending flag of the lowest-numbered in-service device. Remaining in-service devices keep masking, and held requests are then re-evaluated.
- R10: `int_ack` while `int_req` is 0 changes no state.
- R11: If `irq_in` for a device is high in the same cycle that `eoi` retires that device, the device's pending flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_in | input | NUM_DEV | Request lines; bit i is device i+1 |
| en_wr | input | 1 | Load strobe for the mask register |
| en_data | input | NUM_DEV | New mask value, 1 allows the device |
| gie | input | 1 | Global interrupt enable |
| int_ack | input | 1 | Processor acknowledge |
| eoi | input | 1 | End of the current service routine |
| int_req | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector address, valid during an acknowledged cycle |

## Verification
On every cycle, the embedded properties check four things. The global switch always gates the request. An acknowledged vector always carries the F nibble. No request is raised while a device at or above the candidate is in service. Each accepted acknowledge adds exactly one in-service level, each end-of-service removes exactly one, and a stray acknowledge leaves the in-service set unchanged.

Some behaviours depend on the history of requests, so only the directed scenarios can show them. These are the exact vector numbers chosen, the order in which nested levels resume after each end-of-service, the masking of a request that arrived earlier, and the survival of a request that coincides with its own retirement.

// File: rtl/vnpic_pkg.sv
package vnpic_pkg;
  localparam logic [3:0] VEC_BASE = 4'hF;

  function automatic logic [7:0] vec_of(input int unsigned idx);
    logic [3:0] num;
    num = 4'(idx + 1);
    return {VEC_BASE, num};
  endfunction
endpackage

// File: rtl/vnpic_pick.sv
module vnpic_pick #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vnpic_bank.sv
module vnpic_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic         en_wr,
  input  logic [N-1:0] en_data,
  input  logic [N-1:0] set_srv,
  input  logic [N-1:0] clr_srv,
  output logic [N-1:0] flag,
  output logic [N-1:0] en,
  output logic [N-1:0] insrv
);
  logic [N-1:0] flag_d;
  logic [N-1:0] insrv_d;

  for (genvar g = 0; g < N; g++) begin : g_dev
    always_comb begin
      flag_d[g]  = (flag[g] & ~clr_srv[g]) | irq_in[g];
      insrv_d[g] = (insrv[g] & ~clr_srv[g]) | set_srv[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag[g]  <= 1'b0;
        insrv[g] <= 1'b0;
        en[g]    <= 1'b0;
      end else begin
        flag[g]  <= flag_d[g];
        insrv[g] <= insrv_d[g];
        if (en_wr) en[g] <= en_data[g];
      end
    end
  end
endmodule

// File: rtl/vnpic_top.sv
module vnpic_top #(
  parameter int NUM_DEV = 8,
  localparam int IW = $clog2(NUM_DEV)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DEV-1:0] irq_in,
  input  logic               en_wr,
  input  logic [NUM_DEV-1:0] en_data,
  input  logic               gie,
  input  logic               int_ack,
  input  logic               eoi,
  output logic               int_req,
  output logic [7:0]         vector
);
  import vnpic_pkg::*;

  logic               rst_meta, rst_q_n;
  logic [NUM_DEV-1:0] flag, en, insrv, cand_vec, set_srv, clr_srv;
  logic               c_ok, h_ok, above, take;
  logic [IW-1:0]      c_idx, h_idx;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q_n  <= rst_meta;
    end
  end

  vnpic_bank #(.N(NUM_DEV)) u_bank (
    .clk(clk), .rst_n(rst_q_n), .irq_in(irq_in), .en_wr(en_wr),
    .en_data(en_data), .set_srv(set_srv), .clr_srv(clr_srv),
    .flag(flag), .en(en), .insrv(insrv)
  );

  assign cand_vec = flag & en & ~insrv;

  vnpic_pick #(.N(NUM_DEV)) u_cand (.req(cand_vec), .found(c_ok), .idx(c_idx));
  vnpic_pick #(.N(NUM_DEV)) u_top  (.req(insrv),    .found(h_ok), .idx(h_idx));

  always_comb begin
    above   = !h_ok || (c_idx < h_idx);
    int_req = gie && c_ok && above;
    take    = int_req && int_ack;
    for (int i = 0; i < NUM_DEV; i++) begin
      set_srv[i] = take && (c_idx == IW'(i));
      clr_srv[i] = eoi && h_ok && (h_idx == IW'(i));
    end
    vector = take ? vec_of(32'(c_idx)) : 8'h00;
  end

  // R3: global switch gates the request line
  a_r3_gie_gate: assert property (@(posedge clk) disable iff (!rst_q_n)
    !gie |-> !int_req);

  // R5: acknowledged vector carries the fixed upper nibble
  a_r5_vec_base: assert property (@(posedge clk) disable iff (!rst_q_n)
    take |-> vector[7:4] == 4'hF);

  // R7: no level at or above the candidate is in service when requesting
  a_r7_no_blocker: assert property (@(posedge clk) disable iff (!rst_q_n)
    int_req |-> (insrv & ((NUM_DEV'(1) << (c_idx + 1'b1)) - NUM_DEV'(1))) == '0);

  // R6: accepted acknowledge opens exactly one level
  a_r6_one_level: assert property (@(posedge clk) disable iff (!rst_q_n)
    (take && !eoi) |=> $countones(insrv) == $past($countones(insrv)) + 1);

  // R9: end-of-service closes exactly one level
  a_r9_one_close: assert property (@(posedge clk) disable iff (!rst_q_n)
    (eoi && h_ok && !take) |=> $countones(insrv) == $past($countones(insrv)) - 1);

  // R10: stray acknowledge leaves service state alone
  a_r10_stray_ack: assert property (@(posedge clk) disable iff (!rst_q_n)
    (int_ack && !int_req && !eoi) |=> $stable(insrv));
endmodule

// File: tb/test_vnpic_top.sv
module test_vnpic_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] irq_in;
  logic         en_wr;
  logic [N-1:0] en_data;
  logic         gie, int_ack, eoi;
  logic         int_req;
  logic [7:0]   vector;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  vnpic_top #(.NUM_DEV(N)) i_vnpic_top (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .en_wr(en_wr),
    .en_data(en_data), .gie(gie), .int_ack(int_ack), .eoi(eoi),
    .int_req(int_req), .vector(vector)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic raise(input int dev);
    irq_in[dev-1] = 1'b1;
    step();
    irq_in = '0;
    #1;
  endtask

  task automatic ack_expect(input string req, input int vec);
    int_ack = 1'b1;
    #1;
    chk(req, int'(int_req), 1);
    chk(req, int'(vector), vec);
    step();
    int_ack = 1'b0;
    #1;
  endtask

  task automatic end_service();
    eoi = 1'b1;
    step();
    eoi = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; irq_in = '0; en_wr = 0; en_data = '0;
    gie = 1'b1; int_ack = 0; eoi = 0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    #1;
    chk("R1 int_req", int'(int_req), 0);
    chk("R1 vector", int'(vector), 8'h00);
    int_ack = 1'b1; #1;
    chk("R1 vector on stray ack", int'(vector), 8'h00);
    int_ack = 1'b0;
  endtask

  task automatic t_mask_and_gie();
    raise(3);
    chk("R2 masked pending", int'(int_req), 0);
    en_wr = 1; en_data = '1;
    step();
    en_wr = 0; #1;
    chk("R2 flag kept, now allowed", int'(int_req), 1);
    chk("R5 vector idle", int'(vector), 8'h00);
    gie = 0; #1;
    chk("R3 gie off", int'(int_req), 0);
    step(); gie = 1; #1;
    chk("R3 flag kept", int'(int_req), 1);
  endtask

  task automatic t_nesting();
    raise(6);
    ack_expect("R4 R5 device 3 wins", 8'hF3);
    chk("R6 R8 device 6 held", int'(int_req), 0);
    int_ack = 1; step(); int_ack = 0; #1;
    chk("R10 stray ack", int'(int_req), 0);
    raise(1);
    chk("R7 preempt request", int'(int_req), 1);
    ack_expect("R7 device 1 vector", 8'hF1);
    chk("R6 nested in service", int'(int_req), 0);
    end_service();
    chk("R9 device 3 resumes, 6 held", int'(int_req), 0);
    end_service();
    chk("R9 re-evaluate", int'(int_req), 1);
    ack_expect("R10 R9 device 6 vector", 8'hF6);
    end_service();
    chk("R9 all retired", int'(int_req), 0);
  endtask

  task automatic t_same_cycle();
    raise(2);
    ack_expect("R5 device 2 vector", 8'hF2);
    irq_in[1] = 1; eoi = 1;
    step();
    irq_in = '0; eoi = 0; #1;
    chk("R11 re-request survives", int'(int_req), 1);
    ack_expect("R11 device 2 again", 8'hF2);
    end_service();
    chk("R11 retired", int'(int_req), 0);
  endtask

  task automatic t_equal_and_disable();
    raise(7);
    ack_expect("R5 device 7 vector", 8'hF7);
    raise(7);
    chk("R8 equal level held", int'(int_req), 0);
    end_service();
    chk("R9 flag cleared on completion", int'(int_req), 0);
    en_wr = 1; en_data = 8'hEF;
    step(); en_wr = 0; #1;
    raise(5);
    chk("R2 disabled device 5", int'(int_req), 0);
    en_wr = 1; en_data = 8'hFF;
    step(); en_wr = 0; #1;
    ack_expect("R2 device 5 enabled", 8'hF5);
    end_service();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_mask_and_gie();
    t_nesting();
    t_same_cycle();
    t_equal_and_disable();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule